// File: doc/BRIEF.md
# Windowed MAP Decoder Schedule Controller

This controller sequences the three recursion units of a windowed soft-output decoder. A received block of `blk_len` trellis steps is cut into windows of `WIN_LEN` steps, where `WIN_LEN` is chosen near five constraint lengths so that a backward recursion started from an unknown state settles within one window. Only the final window may be shorter. The block does no metric arithmetic. It produces the step addresses, the per-unit enables and the metric-initialisation strobes that the datapath needs.

Time is split into stages of `WIN_LEN` cycles. Stage s runs three things at once. The forward unit sweeps window s in ascending order and writes its forward metrics into one half of a two-bank store; the bank is selected by the window's parity. The training unit sweeps window s+1 in descending order, starting from an unknown state. The output backward unit sweeps window s-1 in descending order and reads the forward metrics stored one stage earlier. At the start of each output sweep, one of two things happens. If a training sweep came before it, a strobe tells the output unit to take over the training unit's end metrics. For the final window, a separate strobe seeds it with the terminated all-zero state instead. A block of W windows therefore takes W+1 stages.

Top module: `swin_sched`

## Requirements
- R1: After reset, `busy`, `done` and every enable and strobe are low. A `start` pulse while idle is accepted only when `blk_len` is between 1 and `MAX_LEN`; in that case `busy` is high in the following cycle. A zero or oversized length leaves the block idle.
- R2: The block is divided into W = ceil(blk_len / WIN_LEN) windows. All windows are `WIN_LEN` steps long except the last, which holds the remaining 1..`WIN_LEN` steps.
- R3: In cycle c of stage s, with s < W and c below the length of window s, `fwd_en` is high. In that cycle `fwd_addr` = s·WIN_LEN + c, and `alpha_wr_addr` = (s mod 2)·WIN_LEN + c, where bit log2(WIN_LEN) is the bank.
- R4: In cycle c of stage s, with s+1 < W and c below the length len of window s+1, `trn_en` is high and `trn_addr` = (s+1)·WIN_LEN + len − 1 − c. Otherwise `trn_en` is low.
- R5: In cycle c of stage s ≥ 1, with c below the length len of window w = s−1, `bwd_en` is high. In that cycle `bwd_addr` = w·WIN_LEN + len − 1 − c, and `alpha_rd_addr` = (w mod 2)·WIN_LEN + len − 1 − c.
- R6: `seed_ld` is high exactly in cycle 0 of stages 1..W−1, which is the first step of each output sweep that follows a training sweep.
- R7: `seed_zero` is high exactly in cycle 0 of stage W, which is the first step of the final window's output sweep. It is never high together with `seed_ld`.
- R8: Every stage lasts `WIN_LEN` cycles. After (W+1)·`WIN_LEN` busy cycles, `busy` falls and `done` is high for exactly one cycle.
- R9: A `start` pulse while busy is ignored. The schedule in progress continues unchanged with the length that was latched at its start.
- R10: Whenever `fwd_en` and `bwd_en` are both high, the forward write and the output read use different banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (sampled while idle) |
| blk_len | input | LEN_W | Block length in trellis steps |
| busy | output | 1 | Schedule in progress |
| done | output | 1 | One-cycle end-of-block pulse |
| fwd_en | output | 1 | Forward unit step enable / forward metric write |
| fwd_addr | output | ADDR_W | Step index for the forward unit |
| alpha_wr_addr | output | LW+1 | Forward metric store write address (bank, offset) |
| trn_en | output | 1 | Training backward unit step enable |
| trn_addr | output | ADDR_W | Step index for the training unit |
| bwd_en | output | 1 | Output backward unit step enable (output valid) |
| bwd_addr | output | ADDR_W | Step index for the output backward unit |
| alpha_rd_addr | output | LW+1 | Forward metric store read address (bank, offset) |
| seed_ld | output | 1 | Output unit takes training end metrics |
| seed_zero | output | 1 | Output unit starts from the terminated zero state |

## Verification
The state lives in a stage counter, an in-stage cycle counter and the latched window count. Any slip in these shows at once on the step addresses, because each pass has a closed-form address in every cycle. The bench compares every output in every busy cycle against that form, so a counter or bank error is reported in the cycle it first appears. A wrong window count or last-window length only shows at the tail of a block, as a misplaced `seed_zero`, a wrong partial-window sweep or a `done` arriving at the wrong time. For that reason, lengths at and around window multiples are exercised as well.

// File: rtl/swin_pkg.sv
package swin_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/swin_ctrl.sv
module swin_ctrl #(
  parameter int WIN_LEN = 16,
  parameter int MAX_LEN = 1024,
  localparam int LW     = $clog2(WIN_LEN),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int MAX_WIN = (MAX_LEN + WIN_LEN - 1) / WIN_LEN,
  localparam int WIN_W  = $clog2(MAX_WIN + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] blk_len,
  output logic             run,
  output logic [WIN_W-1:0] stage,
  output logic [LW-1:0]    cyc,
  output logic [WIN_W-1:0] nwin,
  output logic [LW:0]      last_len,
  output logic             done
);
  import swin_pkg::*;

  phase_t           ph_q, ph_d;
  logic [WIN_W-1:0] stage_q, stage_d;
  logic [LW-1:0]    cyc_q, cyc_d;
  logic [WIN_W-1:0] nwin_q, nwin_d;
  logic [LW:0]      llen_q, llen_d;
  logic             done_q, done_d;
  logic [LEN_W-1:0] len_m1;
  logic             accept;

  assign len_m1 = blk_len - LEN_W'(1);
  assign accept = start && (blk_len != '0) && (blk_len <= LEN_W'(MAX_LEN));

  always_comb begin
    ph_d    = ph_q;
    stage_d = stage_q;
    cyc_d   = cyc_q;
    nwin_d  = nwin_q;
    llen_d  = llen_q;
    done_d  = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (accept) begin
        ph_d    = PH_RUN;
        stage_d = '0;
        cyc_d   = '0;
        nwin_d  = WIN_W'(len_m1 >> LW) + WIN_W'(1);
        llen_d  = {1'b0, len_m1[LW-1:0]} + (LW+1)'(1);
      end
    end else begin
      if (cyc_q == LW'(WIN_LEN - 1)) begin
        cyc_d = '0;
        if (stage_q == nwin_q) begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end else begin
          stage_d = stage_q + WIN_W'(1);
        end
      end else begin
        cyc_d = cyc_q + LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      stage_q <= '0;
      cyc_q   <= '0;
      nwin_q  <= '0;
      llen_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      stage_q <= stage_d;
      cyc_q   <= cyc_d;
      nwin_q  <= nwin_d;
      llen_q  <= llen_d;
      done_q  <= done_d;
    end
  end

  assign run      = (ph_q == PH_RUN);
  assign stage    = stage_q;
  assign cyc      = cyc_q;
  assign nwin     = nwin_q;
  assign last_len = llen_q;
  assign done     = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(run) && !run)); // R8
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> ($stable(nwin) && $stable(last_len))); // R9
  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (stage <= nwin)); // R8
endmodule

// File: rtl/swin_addr_gen.sv
module swin_addr_gen #(
  parameter int WIN_LEN = 16,
  parameter int WIN_W   = 7,
  parameter int ADDR_W  = 10,
  parameter bit DESCEND = 1'b0,
  localparam int LW     = $clog2(WIN_LEN)
) (
  input  logic [WIN_W-1:0]  win,
  input  logic              avail,
  input  logic [LW-1:0]     cyc,
  input  logic [WIN_W-1:0]  last_idx,
  input  logic [LW:0]       last_len,
  output logic              en,
  output logic [ADDR_W-1:0] addr,
  output logic [LW:0]       bank_addr
);
  logic [LW:0]         wlen;
  logic [LW:0]         off;
  logic [WIN_W+LW-1:0] full;

  assign wlen = (win == last_idx) ? last_len : (LW+1)'(WIN_LEN);
  assign en   = avail && ({1'b0, cyc} < wlen);

  generate
    if (DESCEND) begin : g_down
      assign off = wlen - (LW+1)'(1) - {1'b0, cyc};
    end else begin : g_up
      assign off = {1'b0, cyc};
    end
  endgenerate

  assign full      = {win, off[LW-1:0]};
  assign addr      = en ? ADDR_W'(full) : '0;
  assign bank_addr = en ? {win[0], off[LW-1:0]} : '0;
endmodule

// File: rtl/swin_sched.sv
module swin_sched #(
  parameter int WIN_LEN = 16,
  parameter int MAX_LEN = 1024,
  localparam int LW      = $clog2(WIN_LEN),
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int ADDR_W  = $clog2(MAX_LEN),
  localparam int MAX_WIN = (MAX_LEN + WIN_LEN - 1) / WIN_LEN,
  localparam int WIN_W   = $clog2(MAX_WIN + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  blk_len,
  output logic              busy,
  output logic              done,
  output logic              fwd_en,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [LW:0]       alpha_wr_addr,
  output logic              trn_en,
  output logic [ADDR_W-1:0] trn_addr,
  output logic              bwd_en,
  output logic [ADDR_W-1:0] bwd_addr,
  output logic [LW:0]       alpha_rd_addr,
  output logic              seed_ld,
  output logic              seed_zero
);
  logic             run;
  logic [WIN_W-1:0] stage;
  logic [LW-1:0]    cyc;
  logic [WIN_W-1:0] nwin;
  logic [LW:0]      last_len;
  logic [WIN_W-1:0] last_idx;
  logic [WIN_W-1:0] win_trn, win_bwd;
  logic             av_fwd, av_trn, av_bwd;
  logic [LW:0]      trn_bank_unused;
  logic             first_cyc;

  swin_ctrl #(.WIN_LEN(WIN_LEN), .MAX_LEN(MAX_LEN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .run(run), .stage(stage), .cyc(cyc), .nwin(nwin),
    .last_len(last_len), .done(done)
  );

  assign last_idx  = nwin - WIN_W'(1);
  assign win_trn   = stage + WIN_W'(1);
  assign win_bwd   = stage - WIN_W'(1);
  assign av_fwd    = run && (stage < nwin);
  assign av_trn    = run && (win_trn < nwin);
  assign av_bwd    = run && (stage != '0);
  assign first_cyc = run && (cyc == '0);

  swin_addr_gen #(.WIN_LEN(WIN_LEN), .WIN_W(WIN_W), .ADDR_W(ADDR_W), .DESCEND(1'b0)) fwd_i (
    .win(stage), .avail(av_fwd), .cyc(cyc), .last_idx(last_idx), .last_len(last_len),
    .en(fwd_en), .addr(fwd_addr), .bank_addr(alpha_wr_addr)
  );

  swin_addr_gen #(.WIN_LEN(WIN_LEN), .WIN_W(WIN_W), .ADDR_W(ADDR_W), .DESCEND(1'b1)) trn_i (
    .win(win_trn), .avail(av_trn), .cyc(cyc), .last_idx(last_idx), .last_len(last_len),
    .en(trn_en), .addr(trn_addr), .bank_addr(trn_bank_unused)
  );

  swin_addr_gen #(.WIN_LEN(WIN_LEN), .WIN_W(WIN_W), .ADDR_W(ADDR_W), .DESCEND(1'b1)) bwd_i (
    .win(win_bwd), .avail(av_bwd), .cyc(cyc), .last_idx(last_idx), .last_len(last_len),
    .en(bwd_en), .addr(bwd_addr), .bank_addr(alpha_rd_addr)
  );

  assign busy      = run;
  assign seed_ld   = first_cyc && (stage != '0) && (stage < nwin);
  assign seed_zero = first_cyc && (stage == nwin);

  AST_BANK_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && bwd_en) |-> (alpha_wr_addr[LW] != alpha_rd_addr[LW])); // R10
  AST_SEED_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seed_ld && seed_zero)); // R7
  AST_FWD_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && $past(fwd_en)) |-> (fwd_addr == $past(fwd_addr) + ADDR_W'(1))); // R3
  AST_BWD_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (bwd_en && $past(bwd_en) && !seed_ld && !seed_zero) |-> (bwd_addr == $past(bwd_addr) - ADDR_W'(1))); // R5
  AST_TRN_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_en && fwd_en) |-> (trn_addr > fwd_addr)); // R4
  AST_SEED_ON_BWD: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_ld || seed_zero) |-> bwd_en); // R6
endmodule

// File: tb/swin_sched_tb_top.sv
`timescale 1ns/1ps
module swin_sched_tb_top;
  localparam int L       = 16;
  localparam int MAXL    = 1024;
  localparam int LW      = $clog2(L);
  localparam int LEN_W   = $clog2(MAXL + 1);
  localparam int ADDR_W  = $clog2(MAXL);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [LEN_W-1:0]  blk_len = '0;
  logic              busy, done, fwd_en, trn_en, bwd_en, seed_ld, seed_zero;
  logic [ADDR_W-1:0] fwd_addr, trn_addr, bwd_addr;
  logic [LW:0]       alpha_wr_addr, alpha_rd_addr;

  int checks = 0;
  int errors = 0;
  int cyc_count = 0;

  always #2.5 clk = ~clk;

  swin_sched #(.WIN_LEN(L), .MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_len(blk_len),
    .busy(busy), .done(done),
    .fwd_en(fwd_en), .fwd_addr(fwd_addr), .alpha_wr_addr(alpha_wr_addr),
    .trn_en(trn_en), .trn_addr(trn_addr),
    .bwd_en(bwd_en), .bwd_addr(bwd_addr), .alpha_rd_addr(alpha_rd_addr),
    .seed_ld(seed_ld), .seed_zero(seed_zero)
  );

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nwin_of(input int n);
    return (n + L - 1) / L;
  endfunction

  function automatic int wlen_of(input int n, input int w);
    return (w == nwin_of(n) - 1) ? n - w * L : L;
  endfunction

  task automatic check_idle(input string req);
    chk({req, " idle busy"}, busy, 0);
    chk({req, " idle enables"}, {fwd_en, trn_en, bwd_en, seed_ld, seed_zero}, 0);
  endtask

  // Sampled at a negedge; t counts busy cycles since the accepted start.
  task automatic check_cycle(input int n, input int t);
    int s, c, nw, w, len, en;
    s = t / L;
    c = t % L;
    nw = nwin_of(n);
    chk("R1 busy", busy, 1);
    chk("R8 done low while busy", done, 0);
    en = (s < nw) && (c < wlen_of(n, s));
    chk("R3 fwd_en", fwd_en, en);
    if (en) begin
      chk("R3 fwd_addr", fwd_addr, s * L + c);
      chk("R3 alpha_wr_addr", alpha_wr_addr, (s % 2) * L + c);
    end
    w = s + 1;
    en = (w < nw) && (c < wlen_of(n, w));
    chk("R4 trn_en", trn_en, en);
    if (en) begin
      len = wlen_of(n, w);
      chk("R4 trn_addr", trn_addr, w * L + len - 1 - c);
    end
    w = s - 1;
    en = (s >= 1) && (c < wlen_of(n, w));
    chk("R5 bwd_en", bwd_en, en);
    if (en) begin
      len = wlen_of(n, w);
      chk("R5 bwd_addr", bwd_addr, w * L + len - 1 - c);
      chk("R5 alpha_rd_addr", alpha_rd_addr, (w % 2) * L + len - 1 - c);
    end
    chk("R6 seed_ld", seed_ld, (c == 0) && (s >= 1) && (s < nw));
    chk("R7 seed_zero", seed_zero, (c == 0) && (s == nw));
  endtask

  task automatic run_block(input int n, input int noise_len);
    int total;
    total = (nwin_of(n) + 1) * L;
    start = 1'b1;
    blk_len = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
    blk_len = '0;
    for (int t = 0; t < total; t++) begin
      check_cycle(n, t);
      if (noise_len > 0 && (t == 2 || t == total - 2)) begin
        start = 1'b1;                       // R9 start while busy
        blk_len = LEN_W'(noise_len);
      end else begin
        start = 1'b0;
        blk_len = '0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8 done pulse", done, 1);
    chk("R8 busy falls", busy, 0);
    @(negedge clk);
    chk("R8 done single", done, 0);
    chk("R9 no restart after busy start", busy, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    chk("R1 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");

    // R1: zero and oversized lengths ignored
    start = 1'b1; blk_len = '0;
    @(negedge clk);
    start = 1'b0;
    check_idle("R1 zero length");
    start = 1'b1; blk_len = LEN_W'(MAXL + 1);
    @(negedge clk);
    start = 1'b0;
    check_idle("R1 oversized length");

    // R2 directed corners around window multiples
    run_block(1, 0);
    run_block(L, 0);
    run_block(L + 1, 0);
    run_block(2 * L, 0);
    run_block(2 * L - 1, 0);
    run_block(3 * L + 5, 0);
    run_block(MAXL, 0);
    // R9 start pulses mid-run
    run_block(5 * L + 3, 7);
    run_block(2 * L, 900);

    for (int k = 0; k < 12; k++) begin
      n = 1 + int'($urandom_range(MAXL - 1));
      run_block(n, (k % 3 == 0) ? 1 + int'($urandom_range(100)) : 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule